// File: doc/BRIEF.md
# SPI Register-Command Slave with Ready Handshake

This block is the serial front end of a device controller. An external host clocks register commands in over a four-wire SPI link with an active-low chip select. The first byte of every command names a register. A built-in length table maps that register to a total command length of 2 to 8 bytes, counting the address byte. The block gathers the remaining bytes most significant first. It then presents the address, length and data to the controller's command port and pulls the ready pin (`srdy`) low.

While `srdy` is low the serial receiver is blanked, so every clock edge from the host is discarded. The controller holds the command as long as it needs. It releases the block with a one-cycle `cmd_done` pulse, and that same pulse loads an 8-byte reply. The reply is shifted out on MISO, most significant bit first, during the following transfer.

SPI inputs pass through a two-flop synchronizer. Edges are detected in the system clock domain, so the system clock must run at least four times faster than SCLK. The clock edge on which data moves is chosen by a strap sampled during reset.

The command port follows a stream discipline with back-pressure by holding. `cmd_valid` rises together with the command fields and stays high, with the fields frozen, until `cmd_done` is seen. `cmd_done` acts as the ready/accept strobe. No new command can arrive while `cmd_valid` is high, because `srdy` stays low for that whole time.

Top module: `spi_cmd_slave`

## Requirements
- R1: After reset, `srdy` is 1, `cmd_valid` is 0 and `spi_miso` is 0.
- R2: The first byte after chip select falls is the address. The total length is looked up by address: 0x10 and 0x1A take 8 bytes, 0x19 takes 4, and 0x11–0x18, 0x1B–0x1D and 0x30–0x32 take 2. `cmd_len` reports that total.
- R3: Data bytes arrive most significant first and are right-aligned in `cmd_data`. The last byte lands in bits 7:0, and the unused upper bytes are zero.
- R4: In the cycle the final byte completes, `cmd_valid` rises and `srdy` falls together. Both hold until a done pulse arrives.
- R5: While `srdy` is low, SPI traffic has no effect: the command fields and MISO stay unchanged, and no partial bits are carried into the next command.
- R6: A one-cycle `cmd_done` while `cmd_valid` is high returns `srdy` to 1 and `cmd_valid` to 0 in the next cycle. A done pulse while idle has no effect.
- R7: If chip select rises before a command is complete, the partial command is discarded, and the next transfer starts again with an address byte.
- R8: An address missing from the table is treated as a 2-byte command and reported with `cmd_err`=1, which is valid while `cmd_valid` is high.
- R9: `mode_strap` is sampled while `rst_n` is low and held until the next reset. A 1 makes data move on the falling SCLK edge, and a 0 makes it move on the rising edge.
- R10: On an accepted done pulse, `reply_data` is loaded. Each active SCLK edge during a transfer shifts it one place, and `spi_miso` shows its most significant bit, so the reply leaves MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_strap | input | 1 | Edge-mode strap, sampled during reset |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial reply data to the host |
| srdy | output | 1 | High when ready for a new command |
| cmd_valid | output | 1 | A complete command is presented |
| cmd_done | input | 1 | One-cycle accept pulse from the controller |
| cmd_addr | output | 8 | Register address of the command |
| cmd_len | output | 4 | Total command length in bytes |
| cmd_data | output | 56 | Command data, right-aligned |
| cmd_err | output | 1 | Address was not in the length table |
| reply_data | input | 64 | Reply loaded on an accepted done pulse |

## Verification
The bench drives commands of every table length: 8-byte, 4-byte and 2-byte registers, a query, and an unknown address. Together these separate the length lookup from the byte packing and the error flag. A burst sent while the block is busy, and a transfer cut short by chip select, each followed by a clean command, show whether stray bits or counts leak into the next frame. The same traffic is repeated after a reset with the strap low. Because the bench's per-cycle model predicts the exact cycle at which `srdy` falls and MISO changes, it distinguishes falling-edge from rising-edge capture. A reply loaded on done and read back by the host confirms MSB-first output.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int unsigned BYTE_W        = 8;
  localparam int unsigned MAX_CMD_BYTES = 8;
  localparam int unsigned LEN_W         = $clog2(MAX_CMD_BYTES + 1);

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             unknown;
  } cmd_len_t;

  // Total command length (address byte included) chosen by address.
  function automatic cmd_len_t len_lookup(input logic [BYTE_W-1:0] addr);
    cmd_len_t r;
    r.unknown = 1'b0;
    if (addr == 8'h10 || addr == 8'h1A)
      r.len = LEN_W'(8);
    else if (addr == 8'h19)
      r.len = LEN_W'(4);
    else if ((addr >= 8'h11 && addr <= 8'h18) ||
             (addr >= 8'h1B && addr <= 8'h1D) ||
             (addr >= 8'h30 && addr <= 8'h32))
      r.len = LEN_W'(2);
    else begin
      r.len     = LEN_W'(2);
      r.unknown = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_bit_shift.sv
module spi_bit_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         din,
  output logic         byte_done,
  output logic [W-1:0] byte_val
);
  localparam int unsigned CW = $clog2(W);

  logic [CW-1:0] cnt;
  logic [W-2:0]  acc;

  assign byte_val  = {acc, din};
  assign byte_done = shift_en && (cnt == CW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      acc <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (shift_en) begin
      acc <= byte_val[W-2:0];
      cnt <= byte_done ? '0 : cnt + CW'(1);
    end
  end

  AST_COUNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R7
endmodule

// File: rtl/spi_cmd_frame.sv
module spi_cmd_frame
  import spi_cmd_pkg::*;
#(
  parameter int unsigned MAX_BYTES = MAX_CMD_BYTES
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           abort,
  input  logic                           byte_done,
  input  logic [BYTE_W-1:0]              byte_val,
  input  logic                           cmd_done,
  output logic                           srdy,
  output logic                           cmd_valid,
  output logic [BYTE_W-1:0]              cmd_addr,
  output logic [LEN_W-1:0]               cmd_len,
  output logic [(MAX_BYTES-1)*BYTE_W-1:0] cmd_data,
  output logic                           cmd_err
);
  localparam int unsigned DATA_W = (MAX_BYTES - 1) * BYTE_W;

  logic [LEN_W-1:0]  byte_cnt;
  logic [LEN_W-1:0]  need_len;
  logic [BYTE_W-1:0] work_addr;
  logic              work_err;
  logic [DATA_W-1:0] work_data;
  logic [DATA_W-1:0] data_nxt;
  cmd_len_t          info;

  assign info     = len_lookup(byte_val);
  assign data_nxt = {work_data[DATA_W-BYTE_W-1:0], byte_val};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srdy      <= 1'b1;
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
      cmd_len   <= '0;
      cmd_data  <= '0;
      cmd_err   <= 1'b0;
      byte_cnt  <= '0;
      need_len  <= '0;
      work_addr <= '0;
      work_err  <= 1'b0;
      work_data <= '0;
    end else begin
      if (cmd_valid && cmd_done) begin
        cmd_valid <= 1'b0;
        srdy      <= 1'b1;
      end
      if (abort) begin
        byte_cnt <= '0;
      end else if (byte_done) begin
        if (byte_cnt == '0) begin
          work_addr <= byte_val;
          need_len  <= info.len;
          work_err  <= info.unknown;
          work_data <= '0;
          byte_cnt  <= LEN_W'(1);
        end else if (byte_cnt + LEN_W'(1) == need_len) begin
          cmd_addr  <= work_addr;
          cmd_len   <= need_len;
          cmd_err   <= work_err;
          cmd_data  <= data_nxt;
          cmd_valid <= 1'b1;
          srdy      <= 1'b0;
          byte_cnt  <= '0;
        end else begin
          work_data <= data_nxt;
          byte_cnt  <= byte_cnt + LEN_W'(1);
        end
      end
    end
  end

  AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_done) |=> (cmd_valid && !srdy)); // R4
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_done) |=> (srdy && !cmd_valid)); // R6
  AST_LEN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_len >= LEN_W'(2) && cmd_len <= LEN_W'(MAX_BYTES))); // R2
  AST_ERR_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_err) |-> (cmd_len == LEN_W'(2))); // R8
  AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_done) |=> ($stable(cmd_addr) && $stable(cmd_data))); // R5
endmodule

// File: rtl/spi_reply_shift.sv
module spi_reply_shift #(
  parameter int unsigned REPLY_BYTES = 8,
  parameter int unsigned BYTE_BITS   = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             load,
  input  logic [REPLY_BYTES*BYTE_BITS-1:0] load_val,
  input  logic                             shift_en,
  output logic                             miso
);
  localparam int unsigned RW = REPLY_BYTES * BYTE_BITS;

  logic [RW-1:0] reply_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        reply_q <= '0;
    else if (load)     reply_q <= load_val;
    else if (shift_en) reply_q <= {reply_q[RW-2:0], 1'b0};
  end

  assign miso = reply_q[RW-1];
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
  import spi_cmd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned REPLY_BYTES = 8,
  localparam int unsigned DATA_W  = (MAX_CMD_BYTES - 1) * BYTE_W,
  localparam int unsigned REPLY_W = REPLY_BYTES * BYTE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_strap,
  input  logic               spi_sclk,
  input  logic               spi_csn,
  input  logic               spi_mosi,
  output logic               spi_miso,
  output logic               srdy,
  output logic               cmd_valid,
  input  logic               cmd_done,
  output logic [BYTE_W-1:0]  cmd_addr,
  output logic [LEN_W-1:0]   cmd_len,
  output logic [DATA_W-1:0]  cmd_data,
  output logic               cmd_err,
  input  logic [REPLY_W-1:0] reply_data
);
  logic [2:0]        sync_q;
  logic              sclk_s, csn_s, mosi_s, sclk_d;
  logic              mode_q;
  logic              rise, fall, shift_evt, shift_en;
  logic              byte_done;
  logic [BYTE_W-1:0] byte_val;

  spi_in_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_sclk, spi_csn, spi_mosi}), .q(sync_q));

  assign sclk_s = sync_q[2];
  assign csn_s  = sync_q[1];
  assign mosi_s = sync_q[0];

  // Edge mode strap: captured only while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= mode_strap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign rise      = sclk_s & ~sclk_d;
  assign fall      = ~sclk_s & sclk_d;
  assign shift_evt = mode_q ? fall : rise;
  assign shift_en  = shift_evt & ~csn_s & srdy;

  spi_bit_shift #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(csn_s | ~srdy), .shift_en(shift_en),
    .din(mosi_s), .byte_done(byte_done), .byte_val(byte_val));

  spi_cmd_frame #(.MAX_BYTES(MAX_CMD_BYTES)) u_frame (
    .clk(clk), .rst_n(rst_n), .abort(csn_s), .byte_done(byte_done),
    .byte_val(byte_val), .cmd_done(cmd_done), .srdy(srdy),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .cmd_data(cmd_data), .cmd_err(cmd_err));

  spi_reply_shift #(.REPLY_BYTES(REPLY_BYTES), .BYTE_BITS(BYTE_W)) u_reply (
    .clk(clk), .rst_n(rst_n), .load(cmd_valid & cmd_done),
    .load_val(reply_data), .shift_en(shift_en), .miso(spi_miso));

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q)); // R9
  AST_MISO_QUIET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!srdy && $past(!srdy)) |-> $stable(spi_miso)); // R5
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!srdy && cmd_done) |=> srdy); // R6
endmodule

// File: tb/spi_cmd_slave_bench.sv
module spi_cmd_slave_bench;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_strap = 1'b1;
  logic        spi_sclk = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0;
  logic        spi_miso, srdy, cmd_valid, cmd_err;
  logic        cmd_done = 1'b0;
  logic [7:0]  cmd_addr;
  logic [3:0]  cmd_len;
  logic [55:0] cmd_data;
  logic [63:0] reply_data = '0;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] rx_bytes [8];
  int rx_n = 0;

  always #5 clk = ~clk;

  spi_cmd_slave u_spi_cmd_slave (
    .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap), .spi_sclk(spi_sclk),
    .spi_csn(spi_csn), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .srdy(srdy),
    .cmd_valid(cmd_valid), .cmd_done(cmd_done), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_data(cmd_data), .cmd_err(cmd_err),
    .reply_data(reply_data));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ref_len(input int a, output bit unk);
    unk = 0;
    case (a)
      'h10, 'h1A: return 8;
      'h19:       return 4;
      default: begin
        if ((a > 'h10 && a < 'h19) || (a > 'h1A && a < 'h1E) || (a > 'h2F && a < 'h33))
          return 2;
        unk = 1;
        return 2;
      end
    endcase
  endfunction

  // ---------------- behavioural reference model ----------------
  bit q_sclk[2], q_cs[2], q_mo[2];
  bit m_prev, m_mode, m_srdy, m_valid, m_err, m_werr;
  int m_bit, m_nbytes, m_need, m_addr, m_waddr, m_len;
  logic [7:0]  m_acc;
  logic [55:0] m_data, m_wdata;
  logic [63:0] m_reply;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = mode_strap;
      q_sclk = '{0, 0}; q_cs = '{1, 1}; q_mo = '{0, 0};
      m_prev = 0; m_srdy = 1; m_valid = 0; m_err = 0; m_werr = 0;
      m_bit = 0; m_nbytes = 0; m_need = 0; m_addr = 0; m_waddr = 0; m_len = 0;
      m_acc = 0; m_data = 0; m_wdata = 0; m_reply = 0;
    end else begin
      bit s_sclk, s_cs, s_mo, evt, was_ready, unk;
      s_sclk = q_sclk[1]; s_cs = q_cs[1]; s_mo = q_mo[1];
      evt = m_mode ? (m_prev && !s_sclk) : (!m_prev && s_sclk);
      was_ready = m_srdy;
      if (m_valid && cmd_done) begin
        m_valid = 0; m_srdy = 1; m_reply = reply_data;
      end
      if (s_cs || !was_ready) m_bit = 0;
      if (s_cs) m_nbytes = 0;
      else if (evt && was_ready) begin
        m_reply = m_reply << 1;
        m_acc = {m_acc[6:0], s_mo};
        m_bit++;
        if (m_bit == 8) begin
          m_bit = 0;
          if (m_nbytes == 0) begin
            m_waddr = int'(m_acc); m_need = ref_len(m_waddr, unk); m_werr = unk;
            m_wdata = 0; m_nbytes = 1;
          end else begin
            m_wdata = {m_wdata[47:0], m_acc};
            m_nbytes++;
            if (m_nbytes == m_need) begin
              m_addr = m_waddr; m_len = m_need; m_err = m_werr; m_data = m_wdata;
              m_valid = 1; m_srdy = 0; m_nbytes = 0;
            end
          end
        end
      end
      m_prev = s_sclk;
      q_sclk[1] = q_sclk[0]; q_sclk[0] = spi_sclk;
      q_cs[1]   = q_cs[0];   q_cs[0]   = spi_csn;
      q_mo[1]   = q_mo[0];   q_mo[0]   = spi_mosi;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R4 srdy vs model", 64'(srdy), 64'(m_srdy));
      chk("R4 cmd_valid vs model", 64'(cmd_valid), 64'(m_valid));
      chk("R10 miso vs model", 64'(spi_miso), m_reply[63]);
      if (m_valid) begin
        chk("R2 addr vs model", 64'(cmd_addr), 64'(m_addr));
        chk("R2 len vs model", 64'(cmd_len), 64'(m_len));
        chk("R3 data vs model", 64'(cmd_data), 64'(m_data));
        chk("R8 err vs model", 64'(cmd_err), 64'(m_err));
      end
    end
  end

  // ---------------- host-side tasks ----------------
  task automatic send_byte(input logic [7:0] b);
    logic [7:0] rx;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); spi_mosi = b[i];
      repeat (HALF) @(negedge clk);
      rx[i] = spi_miso;
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
    if (rx_n < 8) rx_bytes[rx_n] = rx;
    rx_n++;
  endtask

  task automatic send_cmd(input logic [63:0] v, input int n, input bit cut = 0);
    rx_n = 0;
    spi_csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) send_byte(v[63-8*i -: 8]);
    if (cut) repeat (3) @(negedge clk);
    else     repeat (HALF) @(negedge clk);
    spi_csn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic pulse_done(input logic [63:0] r);
    @(negedge clk); cmd_done = 1'b1; reply_data = r;
    @(negedge clk); cmd_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_cmd(input string tag, input logic [7:0] a, input logic [3:0] l,
                            input logic [55:0] d, input bit e);
    chk({tag, " valid"}, 64'(cmd_valid), 64'd1);
    chk({tag, " srdy low"}, 64'(srdy), 64'd0);
    chk({tag, " addr"}, 64'(cmd_addr), 64'(a));
    chk({tag, " len"}, 64'(cmd_len), 64'(l));
    chk({tag, " data"}, 64'(cmd_data), 64'(d));
    chk({tag, " err"}, 64'(cmd_err), 64'(e));
  endtask

  task automatic do_reset(input bit strap);
    rst_n = 1'b0; mode_strap = strap;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    mode_strap = ~strap;   // later strap changes must not matter (R9)
    @(negedge clk);
  endtask

  initial begin
    do_reset(1'b1);
    chk("R1 srdy after reset", 64'(srdy), 64'd1);
    chk("R1 cmd_valid after reset", 64'(cmd_valid), 64'd0);
    chk("R1 miso after reset", 64'(spi_miso), 64'd0);

    // R6: done pulse while idle has no effect
    pulse_done(64'h0);
    chk("R6 idle done keeps srdy", 64'(srdy), 64'd1);
    chk("R6 idle done keeps valid low", 64'(cmd_valid), 64'd0);

    // R2/R3/R4: 8-byte register
    send_cmd(64'h10_11223344556677, 8);
    expect_cmd("R2 R3 R4 addr10", 8'h10, 4'd8, 56'h11223344556677, 1'b0);

    // R5: traffic while busy is ignored
    send_cmd(64'h19_A1B2C3_00000000, 4);
    expect_cmd("R5 busy ignored", 8'h10, 4'd8, 56'h11223344556677, 1'b0);

    pulse_done(64'h0);
    chk("R6 srdy after done", 64'(srdy), 64'd1);
    chk("R6 valid after done", 64'(cmd_valid), 64'd0);

    // R2/R3: 4-byte register
    send_cmd(64'h19_A1B2C3_00000000, 4);
    expect_cmd("R2 R3 addr19", 8'h19, 4'd4, 56'h000000_00A1B2C3, 1'b0);
    pulse_done(64'h0);

    // R2: 2-byte register
    send_cmd(64'h1B_5A_000000000000, 2);
    expect_cmd("R2 addr1B", 8'h1B, 4'd2, 56'h5A, 1'b0);
    pulse_done(64'h0);

    // R7: aborted transfer discarded, then clean query
    send_cmd(64'h10_0102_0000000000, 3, 1'b1);
    chk("R7 abort produces nothing", 64'(cmd_valid), 64'd0);
    chk("R7 abort keeps srdy", 64'(srdy), 64'd1);
    send_cmd(64'h30_02_000000000000, 2);
    expect_cmd("R7 query after abort", 8'h30, 4'd2, 56'h02, 1'b0);
    pulse_done(64'h0);

    // R8: unknown address
    send_cmd(64'h55_01_000000000000, 2);
    expect_cmd("R8 unknown addr", 8'h55, 4'd2, 56'h01, 1'b1);

    // R10: reply loaded on done, shifted out MSB first
    pulse_done(64'hC35A_0F1E_2D3C_4B69);
    send_cmd(64'h31_00_000000000000, 2);
    chk("R10 first reply byte", 64'(rx_bytes[0]), 64'hC3);
    chk("R10 second reply byte", 64'(rx_bytes[1]), 64'h5A);
    expect_cmd("R2 addr31", 8'h31, 4'd2, 56'h00, 1'b0);
    pulse_done(64'h0);

    // R9: rising-edge mode after reset with strap low
    do_reset(1'b0);
    chk("R1 srdy after second reset", 64'(srdy), 64'd1);
    send_cmd(64'h1A_0123456789ABCD, 8);
    expect_cmd("R9 mode0 addr1A", 8'h1A, 4'd8, 56'h0123456789ABCD, 1'b0);
    pulse_done(64'hA5A5_0000_0000_0000);
    send_cmd(64'h19_DEAD01_00000000, 4);
    chk("R9 R10 mode0 reply byte", 64'(rx_bytes[0]), 64'hA5);
    expect_cmd("R9 mode0 addr19", 8'h19, 4'd4, 56'hDEAD01, 1'b0);
    pulse_done(64'h0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule